// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This controller steps a 14-bit successive-approximation conversion. It runs on the falling edge of the conversion clock. For each trial bit it sets switch controls for a binary-weighted capacitor array and reads back an external comparator, one bit per clock, most significant bit first. Each decided bit is handed to a serial output stage with a one-cycle strobe. The full code is held in a result register once the conversion ends.

A high `rst` holds the controller inactive. Releasing it always starts a calibration placeholder of fixed, parameterised length. A single framing flag, `eoc`, covers both calibration and conversion. A conversion is requested with the active-low `conv_n`. It starts only after the input has been acquired and only when the range select names a running mode. Requests made while the controller is busy are dropped. Between operations the switch vector lets the array track the input, and the tracking pattern depends on the selected range.

Top module: `sarc_ctrl`

## Requirements
- R1: While `rst` is high, `eoc`, `bit_valid`, `sw_ref`, `sw_trk` and `result` are all 0.
- R2: On the first falling clock edge after `rst` goes low, `eoc` rises. It stays high for exactly CAL_CYCLES clock periods and then falls.
- R3: The controller must be idle, with `conv_n` low, `acq_done` high and `mode` equal to 1 or 2. Then on the next falling edge `eoc` rises and `sw_ref` equals 14'h2000, so only bit 13 is on the reference.
- R4: While `acq_done` is low, a low `conv_n` starts nothing. The conversion starts on the first falling edge at which `acq_done` is sampled high.
- R5: During a conversion, `sw_trk` is all zeros. `sw_ref` holds every bit already decided as 1, plus the current trial bit. All bits below the trial bit are 0, meaning switched to ground.
- R6: A low `cmp_hi` keeps the trial bit as 1, and a high `cmp_hi` clears it. With a comparator that reports whether the array value exceeds the input code, `result` ends equal to that code.
- R7: Each of the 14 decisions raises `bit_valid` for exactly one clock, with `bit_data` equal to the decided bit, in order from bit 13 down to bit 0.
- R8: `eoc` falls on the same edge that decides bit 0, so a conversion holds `eoc` high for 14 clock periods. `result` then keeps its value until the next start.
- R9: A low `conv_n` seen during calibration or during a conversion is ignored. No new conversion follows once the operation ends, provided `conv_n` has returned high by then.
- R10: When idle with `mode`=1 (unipolar), `sw_trk`=14'h3FFF and `sw_ref`=0. With `mode`=2 (bipolar), `sw_trk`=14'h1FFF and `sw_ref`=14'h2000. With `mode`=0 or 3 (shutdown), both are 0 and no conversion starts.
- R11: Changing `mode` during a conversion, even to shutdown, does not change that conversion's steps or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high hold; its release launches calibration |
| conv_n | input | 1 | Active-low conversion request |
| acq_done | input | 1 | High once the input has been acquired |
| mode | input | 2 | Range select: 0/3 shutdown, 1 unipolar, 2 bipolar |
| cmp_hi | input | 1 | Comparator output; high means the array value exceeds the input |
| sw_ref | output | 14 | Per-bit capacitor switch to reference (1) or ground (0) |
| sw_trk | output | 14 | Per-bit capacitor switch to the input for tracking |
| eoc | output | 1 | Framing flag, high during calibration or conversion |
| result | output | 14 | Conversion result register |
| bit_valid | output | 1 | One-cycle strobe per decided bit |
| bit_data | output | 1 | Decided bit value, valid with `bit_valid` |

## Verification
Every register updates on the falling edge. The bench changes inputs on the rising edge and samples on the rising edge, half a period after the edge that produced a value. A request therefore shows as `eoc` high at the first rising edge after the falling edge that accepts it. The decision for bit k is visible at the (14-k)-th rising edge after that. `eoc` low and the final `result` appear together with the bit-0 strobe. Calibration is checked by counting the rising edges that find `eoc` high, starting right after reset release, which must total CAL_CYCLES.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    localparam int unsigned SAR_BITS = 14;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_UNI = 2'd1,
        MODE_BIP = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_CAL  = 2'd1,
        ST_IDLE = 2'd2,
        ST_CONV = 2'd3
    } state_e;

    // a range select that allows acquisition and conversion
    function automatic logic mode_runs(input logic [1:0] m);
        return (m == MODE_UNI) || (m == MODE_BIP);
    endfunction

endpackage

// File: rtl/sarc_seq.sv
module sarc_seq
    import sarc_pkg::*;
#(
    parameter int unsigned NBITS      = SAR_BITS,
    parameter int unsigned CAL_CYCLES = 16,
    localparam int unsigned IW = $clog2(NBITS),
    localparam int unsigned CW = $clog2(CAL_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_n,
    input  logic          acq_done,
    input  logic [1:0]    mode,
    output state_e        state,
    output logic [IW-1:0] idx,
    output logic          eoc,
    output logic          start,
    output logic          decide
);

    logic [CW-1:0] cal_cnt;

    always_comb begin
        start  = (state == ST_IDLE) && !conv_n && acq_done && mode_runs(mode);
        decide = (state == ST_CONV);
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            state   <= ST_PARK;
            idx     <= '0;
            cal_cnt <= '0;
            eoc     <= 1'b0;
        end else begin
            unique case (state)
                ST_PARK: begin
                    state   <= ST_CAL;
                    cal_cnt <= CW'(CAL_CYCLES - 1);
                    eoc     <= 1'b1;
                end
                ST_CAL: begin
                    if (cal_cnt == '0) begin
                        state <= ST_IDLE;
                        eoc   <= 1'b0;
                    end else begin
                        cal_cnt <= cal_cnt - 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_CONV;
                        idx   <= IW'(NBITS - 1);
                        eoc   <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (idx == '0) begin
                        state <= ST_IDLE;
                        eoc   <= 1'b0;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                default: state <= ST_PARK;
            endcase
        end
    end

endmodule

// File: rtl/sarc_sar.sv
module sarc_sar
    import sarc_pkg::*;
#(
    parameter int unsigned NBITS = SAR_BITS,
    localparam int unsigned IW = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             decide,
    input  logic [IW-1:0]    idx,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] result,
    output logic             bit_valid,
    output logic             bit_data
);

    // a low comparator keeps the trial bit
    logic keep;
    assign keep = ~cmp_hi;

    always_ff @(negedge clk) begin
        if (rst) begin
            result    <= '0;
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            if (start) begin
                result <= '0;
            end else if (decide) begin
                result[idx] <= keep;
                bit_valid   <= 1'b1;
                bit_data    <= keep;
            end
        end
    end

endmodule

// File: rtl/sarc_dac.sv
module sarc_dac
    import sarc_pkg::*;
#(
    parameter int unsigned NBITS = SAR_BITS,
    localparam int unsigned IW = $clog2(NBITS)
) (
    input  state_e           state,
    input  logic [1:0]       mode,
    input  logic [IW-1:0]    idx,
    input  logic [NBITS-1:0] result,
    output logic [NBITS-1:0] sw_ref,
    output logic [NBITS-1:0] sw_trk
);

    logic converting;
    logic idle_uni;
    logic idle_bip;

    always_comb begin
        converting = (state == ST_CONV);
        idle_uni   = (state == ST_IDLE) && (mode == MODE_UNI);
        idle_bip   = (state == ST_IDLE) && (mode == MODE_BIP);
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_sw
        logic is_trial;
        assign is_trial = (idx == IW'(i));
        if (i == NBITS - 1) begin : g_msb
            // bipolar range parks the MSB on the reference while tracking
            assign sw_ref[i] = converting ? (result[i] | is_trial) : idle_bip;
            assign sw_trk[i] = idle_uni;
        end else begin : g_low
            assign sw_ref[i] = converting & (result[i] | is_trial);
            assign sw_trk[i] = idle_uni | idle_bip;
        end
    end

endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl
    import sarc_pkg::*;
#(
    parameter int unsigned NBITS      = SAR_BITS,
    parameter int unsigned CAL_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_n,
    input  logic             acq_done,
    input  logic [1:0]       mode,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] sw_ref,
    output logic [NBITS-1:0] sw_trk,
    output logic             eoc,
    output logic [NBITS-1:0] result,
    output logic             bit_valid,
    output logic             bit_data
);

    localparam int unsigned IW = $clog2(NBITS);

    state_e        st;
    logic [IW-1:0] idx;
    logic          start;
    logic          decide;

    sarc_seq #(.NBITS(NBITS), .CAL_CYCLES(CAL_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .conv_n   (conv_n),
        .acq_done (acq_done),
        .mode     (mode),
        .state    (st),
        .idx      (idx),
        .eoc      (eoc),
        .start    (start),
        .decide   (decide)
    );

    sarc_sar #(.NBITS(NBITS)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .decide    (decide),
        .idx       (idx),
        .cmp_hi    (cmp_hi),
        .result    (result),
        .bit_valid (bit_valid),
        .bit_data  (bit_data)
    );

    sarc_dac #(.NBITS(NBITS)) u_dac (
        .state  (st),
        .mode   (mode),
        .idx    (idx),
        .result (result),
        .sw_ref (sw_ref),
        .sw_trk (sw_trk)
    );

endmodule

// File: rtl/sarc_ctrl_chk.sv
module sarc_ctrl_chk
    import sarc_pkg::*;
#(
    parameter int unsigned NBITS = SAR_BITS,
    localparam int unsigned IW = $clog2(NBITS)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input state_e           state,
    input logic [IW-1:0]    idx,
    input logic             eoc,
    input logic [NBITS-1:0] sw_ref,
    input logic [NBITS-1:0] sw_trk,
    input logic             bit_valid
);

    // R2
    cal_after_park_chk: assert property (@(negedge clk) disable iff (rst)
        (state == ST_PARK) |=> (state == ST_CAL && eoc));

    // R5
    no_track_in_conv_chk: assert property (@(negedge clk) disable iff (rst)
        (state == ST_CONV) |-> (sw_trk == '0));

    // R5
    low_bits_grounded_chk: assert property (@(negedge clk) disable iff (rst)
        (state == ST_CONV) |-> ((sw_ref & ((NBITS'(1) << idx) - NBITS'(1))) == '0));

    // R7
    strobe_from_conv_chk: assert property (@(negedge clk) disable iff (rst)
        bit_valid |-> $past(state == ST_CONV));

    // R8
    busy_frames_chk: assert property (@(negedge clk) disable iff (rst)
        (state == ST_CONV || state == ST_CAL) |-> eoc);

    // R10
    shutdown_holds_chk: assert property (@(negedge clk) disable iff (rst)
        (state == ST_IDLE && !mode_runs(mode)) |=> (state == ST_IDLE && !eoc));

endmodule

bind sarc_ctrl sarc_ctrl_chk #(.NBITS(NBITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .state     (st),
    .idx       (idx),
    .eoc       (eoc),
    .sw_ref    (sw_ref),
    .sw_trk    (sw_trk),
    .bit_valid (bit_valid)
);

// File: tb/sarc_ctrl_bench.sv
module sarc_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int NB    = 14;
    localparam int CAL   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_n = 1'b1;
    logic          acq_done = 1'b0;
    logic [1:0]    mode = 2'd1;
    logic          cmp_hi;
    logic [NB-1:0] sw_ref, sw_trk, result;
    logic          eoc, bit_valid, bit_data;
    logic [NB-1:0] code_r = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    // comparator model: high when the array value exceeds the input code
    assign cmp_hi = (sw_ref > code_r);

    sarc_ctrl #(.NBITS(NB), .CAL_CYCLES(CAL)) u_sarc_ctrl (
        .clk(clk), .rst(rst), .conv_n(conv_n), .acq_done(acq_done),
        .mode(mode), .cmp_hi(cmp_hi), .sw_ref(sw_ref), .sw_trk(sw_trk),
        .eoc(eoc), .result(result), .bit_valid(bit_valid), .bit_data(bit_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        chk("R1 eoc", 32'(eoc), 0);
        chk("R1 bit_valid", 32'(bit_valid), 0);
        chk("R1 sw_ref", 32'(sw_ref), 0);
        chk("R1 sw_trk", 32'(sw_trk), 0);
        chk("R1 result", 32'(result), 0);
    endtask

    // R2 calibration length, R9 request during calibration ignored
    task automatic t_cal();
        int high_cnt;
        high_cnt = 0;
        rst = 1'b0;
        acq_done = 1'b1;
        for (int i = 1; i <= CAL + 1; i++) begin
            @(posedge clk);
            if (eoc) high_cnt++;
            if (i == 1) chk("R2 eoc rises", 32'(eoc), 1);
            if (i == 3) conv_n = 1'b0;
            if (i == 4) conv_n = 1'b1;
        end
        chk("R2 eoc high count", 32'(high_cnt), 32'(CAL));
        chk("R2 eoc falls", 32'(eoc), 0);
        repeat (3) @(posedge clk);
        chk("R9 no start after cal", 32'(eoc), 0);
    endtask

    task automatic t_track();
        mode = 2'd1;
        @(posedge clk);
        chk("R10 uni trk", 32'(sw_trk), 32'h3FFF);
        chk("R10 uni ref", 32'(sw_ref), 0);
        mode = 2'd2;
        @(posedge clk);
        chk("R10 bip trk", 32'(sw_trk), 32'h1FFF);
        chk("R10 bip ref", 32'(sw_ref), 32'h2000);
        mode = 2'd1;
    endtask

    task automatic t_shutdown(input logic [1:0] m);
        mode = m;
        acq_done = 1'b1;
        conv_n = 1'b0;
        repeat (4) @(posedge clk);
        chk("R10 off no start", 32'(eoc), 0);
        chk("R10 off ref", 32'(sw_ref), 0);
        chk("R10 off trk", 32'(sw_trk), 0);
        conv_n = 1'b1;
        mode = 2'd1;
        @(posedge clk);
    endtask

    task automatic t_convert(input logic [NB-1:0] code, input logic [1:0] m,
                             input int acq_wait, input bit mode_flip, input bit req_pulse);
        logic [31:0] exp_ref;
        code_r = code;
        mode = m;
        acq_done = (acq_wait == 0);
        conv_n = 1'b0;
        for (int w = 0; w < acq_wait; w++) begin
            @(posedge clk);
            chk("R4 waits for acquisition", 32'(eoc), 0);
        end
        acq_done = 1'b1;
        @(posedge clk);
        conv_n = 1'b1;
        chk("R3 eoc rises", 32'(eoc), 1);
        chk("R3 msb trial", 32'(sw_ref), 32'h2000);
        chk("R5 trk off", 32'(sw_trk), 0);
        for (int k = NB - 1; k >= 0; k--) begin
            @(posedge clk);
            if (mode_flip && k == 10) mode = 2'd0;
            if (req_pulse && k == 10) conv_n = 1'b0;
            if (req_pulse && k == 9)  conv_n = 1'b1;
            chk("R7 strobe", 32'(bit_valid), 1);
            chk("R6 R7 bit value", 32'(bit_data), 32'(code[k]));
            if (k > 0) begin
                exp_ref = (32'(code) & (32'h3FFF << k) & 32'h3FFF) | (32'd1 << (k - 1));
                chk("R5 trial vector", 32'(sw_ref), exp_ref);
                chk("R8 eoc still high", 32'(eoc), 1);
            end else begin
                chk("R8 eoc falls with lsb", 32'(eoc), 0);
            end
        end
        chk("R6 result", 32'(result), 32'(code));
        @(posedge clk);
        chk("R7 strobe ends", 32'(bit_valid), 0);
        chk("R8 R9 stays idle", 32'(eoc), 0);
        chk("R8 result held", 32'(result), 32'(code));
        mode = 2'd1;
        @(posedge clk);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cal();
        t_track();
        t_shutdown(2'd0);
        t_shutdown(2'd3);
        t_convert(14'h2AAA, 2'd1, 0, 1'b0, 1'b0);
        t_convert(14'h0000, 2'd1, 0, 1'b0, 1'b0);
        t_convert(14'h3FFF, 2'd2, 0, 1'b0, 1'b0);
        t_convert(14'h1555, 2'd1, 3, 1'b0, 1'b0);   // R4
        t_convert(14'h2000, 2'd2, 0, 1'b1, 1'b0);   // R11
        t_convert(14'h1FFF, 2'd1, 0, 1'b0, 1'b1);   // R9
        t_convert(14'h0001, 2'd1, 1, 1'b1, 1'b1);   // R11 R9 R4
        t_reset();
        t_cal();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule